// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit register file and a little-endian, word-wide data memory. It does all of the lane steering for a load/store unit. For stores it places the register bytes on the correct memory lanes and produces the byte-write enables. For loads it extracts and extends the addressed bytes from the returned memory word. It also supports two unaligned load forms that merge memory bytes into the old register value. The two matching store forms write only part of a word.

Each cycle the block takes an operation code, an effective byte address, the current register value and the memory read word. After one clock it presents registered results: the word-aligned address, the write data and enables, the load result, read/write access strobes and separate alignment-error flags for loads and stores. A misaligned word or halfword access raises its error flag and produces no access at all. Address translation and the memory itself live elsewhere.

Top module: `lsa_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge, whatever the inputs are.
- R2: Operation codes are 0 none, 1 byte load signed, 2 byte load unsigned, 3 halfword load signed, 4 halfword load unsigned, 5 word load, 6 fill-high load, 7 fill-low load, 8 byte store, 9 halfword store, 10 word store, 11 partial-high store, 12 partial-low store; codes 13 to 15 behave as none. Outputs reflect the inputs sampled at the previous rising edge, and `word_addr` equals `addr` with bits [1:0] cleared.
- R3: A byte load returns memory lane `addr[1:0]` (lane k = bits 8k+7..8k), sign-extended for code 1 and zero-extended for code 2.
- R4: A halfword load returns bits [15:0] when `addr[1]`=0 or bits [31:16] when `addr[1]`=1, sign-extended for code 3 and zero-extended for code 4.
- R5: A word load returns the whole memory word.
- R6: A fill-high load with offset o=`addr[1:0]` places the low o+1 memory bytes in the top o+1 bytes of the result and keeps the remaining low register bytes; offset 3 returns the whole memory word.
- R7: A fill-low load with offset o places memory bytes o..3 in the low 4-o result bytes and keeps the top o register bytes; offset 0 returns the whole memory word.
- R8: A byte store replicates reg[7:0] on all four lanes with only enable bit `addr[1:0]` set; a halfword store replicates reg[15:0] on both halves with enables 0011 (`addr[1]`=0) or 1100 (`addr[1]`=1).
- R9: A word store writes the register value with enables 1111.
- R10: A partial-high store with offset o writes the register shifted right by 8*(3-o) bits with enables on lanes 0..o (0001, 0011, 0111, 1111).
- R11: A partial-low store with offset o writes the register shifted left by 8*o bits with enables on lanes o..3 (1111, 1110, 1100, 1000).
- R12: A halfword access with `addr[0]`=1 or a word access with `addr[1:0]`≠0 sets `err_load` (loads) or `err_store` (stores), and gives `mem_rd`=0, `mem_wr`=0, `byte_en`=0, `wr_data`=0 and `ld_result` equal to `reg_val`.
- R13: An accepted load gives `mem_rd`=1, `byte_en`=0, `wr_data`=0. An accepted store gives `mem_wr`=1 and `ld_result`=`reg_val`. A none code gives no strobe, no error, `byte_en`=0, `wr_data`=0 and `ld_result`=`reg_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code (see R2) |
| addr | input | 32 | Effective byte address |
| reg_val | input | 32 | Register value: store source and old value for merges |
| mem_rdata | input | 32 | Word read from memory at `word_addr` |
| word_addr | output | 32 | Word-aligned memory address |
| wr_data | output | 32 | Lane-steered store data |
| byte_en | output | 4 | Byte-write enables, bit k for lane k |
| ld_result | output | 32 | Value to write back to the register |
| mem_rd | output | 1 | Accepted load access |
| mem_wr | output | 1 | Accepted store access |
| err_load | output | 1 | Misaligned load |
| err_store | output | 1 | Misaligned store |

## Verification
On every cycle the assertions check several structural relations. An error flag never coincides with any access strobe or enable. The two error flags never rise together, and a load never drives write enables. A byte store enables exactly one lane, an accepted word store enables all four, and the partial stores always include their anchoring edge lane. Only the bench's scenarios can show the exact data values: the sign and zero extension, the byte-by-byte merges of the fill loads at each offset, and the shifted store data. Each of these is compared against an expected value written out from the requirements.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [3:0] {
    OP_NONE       = 4'd0,
    OP_LD_B       = 4'd1,
    OP_LD_BU      = 4'd2,
    OP_LD_H       = 4'd3,
    OP_LD_HU      = 4'd4,
    OP_LD_W       = 4'd5,
    OP_LD_FILL_HI = 4'd6,
    OP_LD_FILL_LO = 4'd7,
    OP_ST_B       = 4'd8,
    OP_ST_H       = 4'd9,
    OP_ST_W       = 4'd10,
    OP_ST_PART_HI = 4'd11,
    OP_ST_PART_LO = 4'd12
  } lsa_op_e;

  function automatic logic op_is_load(input lsa_op_e o);
    return (o >= OP_LD_B) && (o <= OP_LD_FILL_LO);
  endfunction

  function automatic logic op_is_store(input lsa_op_e o);
    return (o >= OP_ST_B) && (o <= OP_ST_PART_LO);
  endfunction

  function automatic logic op_is_half(input lsa_op_e o);
    return (o == OP_LD_H) || (o == OP_LD_HU) || (o == OP_ST_H);
  endfunction

  function automatic logic op_is_word(input lsa_op_e o);
    return (o == OP_LD_W) || (o == OP_ST_W);
  endfunction

endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
  import lsa_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  lsa_op_e          op,
  input  logic [OFF_W-1:0] off,
  output logic             is_load,
  output logic             is_store,
  output logic             err_load,
  output logic             err_store
);

  logic misaligned;

  always_comb begin
    is_load    = op_is_load(op);
    is_store   = op_is_store(op);
    misaligned = (op_is_half(op) && off[0]) ||
                 (op_is_word(op) && (off != '0));
    err_load   = is_load && misaligned;
    err_store  = is_store && misaligned;
  end

endmodule

// File: rtl/lsa_load_merge.sv
module lsa_load_merge
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  lsa_op_e           op,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] result
);

  logic [7:0]  sel_byte;
  logic [15:0] sel_half;
  int          o;

  always_comb begin
    o        = int'(off);
    sel_byte = 8'(mem_word >> (o * 8));
    sel_half = 16'(mem_word >> ((o / 2) * 16));
    result   = reg_val;
    unique case (op)
      OP_LD_B:  result = {{(DATA_W-8){sel_byte[7]}}, sel_byte};
      OP_LD_BU: result = {{(DATA_W-8){1'b0}}, sel_byte};
      OP_LD_H:  result = {{(DATA_W-16){sel_half[15]}}, sel_half};
      OP_LD_HU: result = {{(DATA_W-16){1'b0}}, sel_half};
      OP_LD_W:  result = mem_word;
      OP_LD_FILL_HI: begin
        // top o+1 lanes take memory lanes 0..o
        for (int j = 0; j < LANES; j++) begin
          if (j >= LANES - 1 - o)
            result[8*j +: 8] = mem_word[8*(j - (LANES - 1 - o)) +: 8];
        end
      end
      OP_LD_FILL_LO: begin
        // low LANES-o lanes take memory lanes o..LANES-1
        for (int j = 0; j < LANES; j++) begin
          if (j <= LANES - 1 - o)
            result[8*j +: 8] = mem_word[8*(j + o) +: 8];
        end
      end
      default: result = reg_val;
    endcase
  end

endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  lsa_op_e           op,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] reg_val,
  output logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  be
);

  int o;

  always_comb begin
    o    = int'(off);
    data = '0;
    be   = '0;
    unique case (op)
      OP_ST_B: begin
        data = {LANES{reg_val[7:0]}};
        be   = LANES'(1) << o;
      end
      OP_ST_H: begin
        data = {(LANES/2){reg_val[15:0]}};
        be   = LANES'(3) << ((o / 2) * 2);
      end
      OP_ST_W: begin
        data = reg_val;
        be   = '1;
      end
      OP_ST_PART_HI: begin
        // lanes 0..o carry the top o+1 register bytes
        for (int j = 0; j < LANES; j++) begin
          if (j <= o) begin
            data[8*j +: 8] = reg_val[8*(j + LANES - 1 - o) +: 8];
            be[j]          = 1'b1;
          end
        end
      end
      OP_ST_PART_LO: begin
        // lanes o..LANES-1 carry the low LANES-o register bytes
        for (int j = 0; j < LANES; j++) begin
          if (j >= o) begin
            data[8*j +: 8] = reg_val[8*(j - o) +: 8];
            be[j]          = 1'b1;
          end
        end
      end
      default: begin
        data = '0;
        be   = '0;
      end
    endcase
  end

endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  byte_en,
  output logic [DATA_W-1:0] ld_result,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              err_load,
  output logic              err_store
);

  lsa_op_e          op_e;
  logic [OFF_W-1:0] off;
  logic             is_ld, is_st, e_ld, e_st;
  logic [DATA_W-1:0] merged, st_data;
  logic [LANES-1:0]  st_be;

  assign op_e = lsa_op_e'(op);
  assign off  = addr[OFF_W-1:0];

  lsa_align_check #(.OFF_W(OFF_W)) u_chk (
    .op(op_e), .off(off),
    .is_load(is_ld), .is_store(is_st),
    .err_load(e_ld), .err_store(e_st)
  );

  lsa_load_merge #(.DATA_W(DATA_W)) u_ld (
    .op(op_e), .off(off), .reg_val(reg_val),
    .mem_word(mem_rdata), .result(merged)
  );

  lsa_store_steer #(.DATA_W(DATA_W)) u_st (
    .op(op_e), .off(off), .reg_val(reg_val),
    .data(st_data), .be(st_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_addr <= '0;
      wr_data   <= '0;
      byte_en   <= '0;
      ld_result <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      err_load  <= 1'b0;
      err_store <= 1'b0;
    end else begin
      word_addr <= {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      err_load  <= e_ld;
      err_store <= e_st;
      mem_rd    <= is_ld && !e_ld;
      mem_wr    <= is_st && !e_st;
      byte_en   <= (is_st && !e_st) ? st_be : '0;
      wr_data   <= (is_st && !e_st) ? st_data : '0;
      ld_result <= (is_ld && !e_ld) ? merged : reg_val;
    end
  end

  // R12: an alignment error never comes with an access
  p_err_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (err_load || err_store) |-> (byte_en == '0 && !mem_rd && !mem_wr));

  // R12: one operation cannot be both a faulting load and store
  p_err_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(err_load && err_store));

  // R13: a load never drives write enables
  p_load_no_be_r13: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (byte_en == '0 && !mem_wr));

  // R8: a byte store enables exactly one lane
  p_byte_one_lane_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_ST_B) |-> ($countones(byte_en) == 1));

  // R9: an aligned word store enables every lane
  p_word_full_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_ST_W && $past(addr[OFF_W-1:0]) == '0)
      |-> (byte_en == '1));

  // R10: a partial-high store always includes lane 0
  p_part_hi_lane0_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_ST_PART_HI) |-> byte_en[0]);

  // R11: a partial-low store always includes the top lane
  p_part_lo_top_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_ST_PART_LO) |-> byte_en[LANES-1]);

endmodule

// File: tb/tb_lsa_aligner.sv
module tb_lsa_aligner;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op;
  logic [31:0] addr, reg_val, mem_rdata;
  logic [31:0] word_addr, wr_data, ld_result;
  logic [3:0]  byte_en;
  logic        mem_rd, mem_wr, err_load, err_store;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  lsa_aligner dut (
    .clk(clk), .rst(rst), .op(op), .addr(addr), .reg_val(reg_val),
    .mem_rdata(mem_rdata), .word_addr(word_addr), .wr_data(wr_data),
    .byte_en(byte_en), .ld_result(ld_result), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .err_load(err_load), .err_store(err_store)
  );

  localparam logic [31:0] RV = 32'h11223344;
  localparam logic [31:0] MV = 32'h8899AABB;
  localparam logic [31:0] A0 = 32'h00001000;
  localparam logic [31:0] A1 = 32'h00001001;
  localparam logic [31:0] A2 = 32'h00001002;
  localparam logic [31:0] A3 = 32'h00001003;
  // flags: {err_load, err_store, mem_rd, mem_wr}
  localparam logic [3:0] FL = 4'b0010;
  localparam logic [3:0] FS = 4'b0001;
  localparam logic [3:0] EL = 4'b1000;
  localparam logic [3:0] ES = 4'b0100;
  localparam logic [3:0] FN = 4'b0000;

  localparam int NV = 35;
  // {op, addr, reg, mem, exp_ld, exp_wd, exp_be, exp_flags}
  localparam logic [171:0] VEC [NV] = '{
    {4'd1,  A0, RV, MV,           32'hFFFFFFBB, 32'h0, 4'b0000, FL},
    {4'd2,  A3, RV, MV,           32'h00000088, 32'h0, 4'b0000, FL},
    {4'd1,  A1, RV, 32'h00007F00, 32'h0000007F, 32'h0, 4'b0000, FL},
    {4'd3,  A2, RV, MV,           32'hFFFF8899, 32'h0, 4'b0000, FL},
    {4'd4,  A0, RV, MV,           32'h0000AABB, 32'h0, 4'b0000, FL},
    {4'd3,  A1, RV, MV,           RV,           32'h0, 4'b0000, EL},
    {4'd5,  A0, RV, MV,           32'h8899AABB, 32'h0, 4'b0000, FL},
    {4'd5,  A2, RV, MV,           RV,           32'h0, 4'b0000, EL},
    {4'd6,  A0, RV, MV,           32'hBB223344, 32'h0, 4'b0000, FL},
    {4'd6,  A1, RV, MV,           32'hAABB3344, 32'h0, 4'b0000, FL},
    {4'd6,  A2, RV, MV,           32'h99AABB44, 32'h0, 4'b0000, FL},
    {4'd6,  A3, RV, MV,           32'h8899AABB, 32'h0, 4'b0000, FL},
    {4'd7,  A0, RV, MV,           32'h8899AABB, 32'h0, 4'b0000, FL},
    {4'd7,  A1, RV, MV,           32'h118899AA, 32'h0, 4'b0000, FL},
    {4'd7,  A2, RV, MV,           32'h11228899, 32'h0, 4'b0000, FL},
    {4'd7,  A3, RV, MV,           32'h11223388, 32'h0, 4'b0000, FL},
    {4'd8,  A2, RV, MV,           RV, 32'h44444444, 4'b0100, FS},
    {4'd9,  A2, RV, MV,           RV, 32'h33443344, 4'b1100, FS},
    {4'd9,  A0, RV, MV,           RV, 32'h33443344, 4'b0011, FS},
    {4'd9,  A3, RV, MV,           RV, 32'h00000000, 4'b0000, ES},
    {4'd10, A0, RV, MV,           RV, 32'h11223344, 4'b1111, FS},
    {4'd10, A1, RV, MV,           RV, 32'h00000000, 4'b0000, ES},
    {4'd11, A0, RV, MV,           RV, 32'h00000011, 4'b0001, FS},
    {4'd11, A1, RV, MV,           RV, 32'h00001122, 4'b0011, FS},
    {4'd11, A2, RV, MV,           RV, 32'h00112233, 4'b0111, FS},
    {4'd11, A3, RV, MV,           RV, 32'h11223344, 4'b1111, FS},
    {4'd12, A0, RV, MV,           RV, 32'h11223344, 4'b1111, FS},
    {4'd12, A1, RV, MV,           RV, 32'h22334400, 4'b1110, FS},
    {4'd12, A2, RV, MV,           RV, 32'h33440000, 4'b1100, FS},
    {4'd12, A3, RV, MV,           RV, 32'h44000000, 4'b1000, FS},
    {4'd0,  A1, RV, MV,           RV, 32'h00000000, 4'b0000, FN},
    {4'd15, A0, RV, MV,           RV, 32'h00000000, 4'b0000, FN},
    {4'd2,  32'hFFFFFFF7, RV, MV, 32'h00000088, 32'h0, 4'b0000, FL},
    {4'd8,  A0, RV, MV,           RV, 32'h44444444, 4'b0001, FS},
    {4'd4,  A3, RV, MV,           RV,           32'h0, 4'b0000, EL}
  };

  function automatic string req_of(input logic [3:0] o, input logic [3:0] fl);
    if (fl[3] || fl[2]) return "R12";
    case (o)
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5:       return "R5";
      4'd6:       return "R6";
      4'd7:       return "R7";
      4'd8, 4'd9: return "R8";
      4'd10:      return "R9";
      4'd11:      return "R10";
      4'd12:      return "R11";
      default:    return "R13";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [31:0] a,
                       input logic [31:0] r, input logic [31:0] m);
    op = o; addr = a; reg_val = r; mem_rdata = m;
  endtask

  initial begin
    drive(4'd10, A0, RV, MV);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset holds every output at zero even with a store applied
    chk("R1", "wr_data", wr_data, 32'h0);
    chk("R1", "byte_en", {28'h0, byte_en}, 32'h0);
    chk("R1", "ld_result", ld_result, 32'h0);
    chk("R1", "word_addr", word_addr, 32'h0);
    chk("R1", "flags", {28'h0, err_load, err_store, mem_rd, mem_wr}, 32'h0);

    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [171:0] v;
      string rq;
      v = VEC[i];
      drive(v[171:168], v[167:136], v[135:104], v[103:72]);
      @(posedge clk);
      #1;
      rq = req_of(v[171:168], v[3:0]);
      chk(rq, "ld_result", ld_result, v[71:40]);
      chk(rq, "wr_data", wr_data, v[39:8]);
      chk(rq, "byte_en", {28'h0, byte_en}, {28'h0, v[7:4]});
      chk((v[3:2] != 2'b00) ? "R12" : "R13", "flags",
          {28'h0, err_load, err_store, mem_rd, mem_wr}, {28'h0, v[3:0]});
      chk("R2", "word_addr", word_addr, {v[167:138], 2'b00});
      @(negedge clk);
    end

    // R2: outputs hold until the next edge after the inputs change
    drive(4'd12, A1, RV, MV);
    @(posedge clk); #1;
    @(negedge clk);
    drive(4'd0, 32'hABCD0003, 32'h0, 32'h0);
    #2;
    chk("R2", "held wr_data", wr_data, 32'h22334400);
    chk("R2", "held word_addr", word_addr, 32'h00001000);
    @(posedge clk); #1;
    chk("R2", "next word_addr", word_addr, 32'hABCD0000);
    chk("R13", "none wr_data", wr_data, 32'h0);

    // R13: a store leaves the register value to pass through
    @(negedge clk);
    drive(4'd8, A3, 32'hCAFE00F0, 32'h12345678);
    @(posedge clk); #1;
    chk("R13", "store ld_result", ld_result, 32'hCAFE00F0);
    chk("R8", "byte lane3 data", wr_data, 32'hF0F0F0F0);
    chk("R8", "byte lane3 be", {28'h0, byte_en}, 32'h8);

    // R1: mid-run reset clears active outputs
    @(negedge clk);
    drive(4'd10, A0, RV, MV);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", "mid reset wr_data", wr_data, 32'h0);
    chk("R1", "mid reset mem_wr", {31'h0, mem_wr}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R9", "after reset wr_data", wr_data, RV);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule